// File: doc/BRIEF.md
# JTAG Debug Access Register Controller

This block holds the data-register side of a debug transport that connects a JTAG scan chain to a debug module bus. The TAP state machine is not part of it. It receives capture, shift and update strobes, plus a select line that picks which of its two scan registers is active. The block does not decode JTAG instructions itself.

The wide access register carries three fields: an operation code in bits [1:0], a 32-bit data word in bits [33:2], and an ABITS-wide address above the data. An update that names a read or a write issues one request on a valid/ready request channel. A capture loads three things: the address of the last issued request, the data of the last accepted response, and a two-bit status code.

The status is sticky. An error response sets it. So does a new transfer that arrives while the previous one is still outstanding. While it is set, scanned transfers are dropped.

The 32-bit control register reports four things: an idle-cycle hint, the sticky status, the address width and a version number. Its update can clear the status. It can also abandon an outstanding request.

Top module: `dmi_access_ctrl`

## Requirements
- R1: A capture of the access register loads {last issued address, last accepted response data, status} into bits {[ABITS+33:34], [33:2], [1:0]}, and all fields are zero after reset. The register shifts toward bit 0, with tdo showing bit 0 and tdi entering the top bit.
- R2: An update with op 1 (read) or op 2 (write), status 0 and nothing outstanding raises req_valid_o with the scanned address. req_write_o is 1 for op 2, and op 2 also carries the scanned data. All of these hold steady until req_ready_i is seen high.
- R3: An update with op 0 or op 3 issues no request and leaves the status and the captured address unchanged, even while a transfer is outstanding.
- R4: A read or write update that arrives while a request is waiting for acceptance or for its response is discarded and sets the status to 3.
- R5: A response with rsp_err_i high, arriving while the status is 0, sets the status to 2. Response data is stored whether or not the error flag is set.
- R6: While the status is nonzero, read and write updates issue no request and do not change the captured address.
- R7: A control-register update with bit 16 set returns the status to 0, after which transfers are accepted again.
- R8: A control-register update with bit 17 set clears the status and drops any pending request at once. A response to the abandoned transfer is then ignored, and the next transfer is accepted.
- R9: A control-register capture returns the version 1 in [3:0], ABITS in [9:4], the status in [11:10] and IDLE_HINT in [14:12]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_sel_i | input | 1 | 1 selects the access register, 0 the control register |
| capture_i | input | 1 | Capture strobe for the selected register |
| shift_i | input | 1 | Shift strobe for the selected register |
| update_i | input | 1 | Update strobe for the selected register |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (bit 0 of selected register) |
| req_valid_o | output | 1 | Request valid toward the debug module bus |
| req_ready_i | input | 1 | Request accepted |
| req_write_o | output | 1 | 1 for write, 0 for read |
| req_addr_o | output | ABITS | Request address |
| req_wdata_o | output | 32 | Write data |
| rsp_valid_i | input | 1 | Response valid (single cycle) |
| rsp_rdata_i | input | 32 | Response data |
| rsp_err_i | input | 1 | Response reports an error |

## Verification
Several kinds of transfer are run through the block. Plain reads and writes with a fast responder show that the fields are routed correctly and that response data comes back. A write held off by a low ready shows that the request stays steady. A transfer scanned in while a slow response is still pending separates the busy rule from ordinary queuing. An error response followed by further scans shows that the status is sticky and that dropped scans leave no trace. Reserved and nop ops, one of them sent during an outstanding transfer, confirm that no status is raised. A hard reset issued both before and after acceptance shows that a late response is discarded.

// File: rtl/dmiac_pkg.sv
package dmiac_pkg;
   typedef enum logic [1:0] {
      DOP_NOP   = 2'd0,
      DOP_READ  = 2'd1,
      DOP_WRITE = 2'd2,
      DOP_RSVD  = 2'd3
   } dop_e;

   typedef enum logic [1:0] {
      DST_OK   = 2'd0,
      DST_RSVD = 2'd1,
      DST_FAIL = 2'd2,
      DST_BUSY = 2'd3
   } dst_e;

   localparam int CSR_W        = 32;
   localparam int CSR_CLR_BIT  = 16;
   localparam int CSR_HARD_BIT = 17;
   localparam int CSR_VERSION  = 1;
endpackage

// File: rtl/dmiac_scanreg.sv
module dmiac_scanreg #(
   parameter int W      = 32,
   parameter int TAP_LO = 0,
   parameter int TAP_HI = W - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic [W-1:0]             load_val_i,
   input  logic                     shift_i,
   input  logic                     tdi_i,
   output logic [TAP_HI-TAP_LO:0]   q_o,
   output logic                     tdo_o
);
   logic [W-1:0] sr;

   if (W < 2) begin : g_bad_w
      $error("dmiac_scanreg: W must be at least 2");
   end
   if (TAP_LO < 0 || TAP_HI >= W || TAP_HI < TAP_LO) begin : g_bad_tap
      $error("dmiac_scanreg: tap range outside register");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr <= '0;
      else if (load_i)  sr <= load_val_i;
      else if (shift_i) sr <= {tdi_i, sr[W-1:1]};
   end

   assign q_o   = sr[TAP_HI:TAP_LO];
   assign tdo_o = sr[0];
endmodule

// File: rtl/dmiac_link.sv
module dmiac_link #(
   parameter int ABITS  = 7,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic              issue_write_i,
   input  logic [ABITS-1:0]  issue_addr_i,
   input  logic [DATA_W-1:0] issue_data_i,
   input  logic              abandon_i,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic              req_write_o,
   output logic [ABITS-1:0]  req_addr_o,
   output logic [DATA_W-1:0] req_wdata_o,
   input  logic              rsp_valid_i,
   input  logic [DATA_W-1:0] rsp_rdata_i,
   input  logic              rsp_err_i,
   output logic              outstanding_o,
   output logic              rsp_err_o,
   output logic [DATA_W-1:0] last_data_o
);
   logic waiting;
   logic rsp_taken;

   assign rsp_taken = waiting && rsp_valid_i && !abandon_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid_o <= 1'b0;
         req_write_o <= 1'b0;
         req_addr_o  <= '0;
         req_wdata_o <= '0;
         waiting     <= 1'b0;
         last_data_o <= '0;
      end else if (abandon_i) begin
         req_valid_o <= 1'b0;
         waiting     <= 1'b0;
      end else if (issue_i) begin
         req_valid_o <= 1'b1;
         req_write_o <= issue_write_i;
         req_addr_o  <= issue_addr_i;
         req_wdata_o <= issue_data_i;
      end else begin
         if (req_valid_o && req_ready_i) begin
            req_valid_o <= 1'b0;
            waiting     <= 1'b1;
         end
         if (rsp_taken) begin
            waiting     <= 1'b0;
            last_data_o <= rsp_rdata_i;
         end
      end
   end

   assign outstanding_o = req_valid_o || waiting;
   assign rsp_err_o     = rsp_taken && rsp_err_i;

   // R2: request fields stay steady until accepted
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i && !abandon_i)
      |=> (req_valid_o && $stable(req_addr_o) && $stable(req_wdata_o) && $stable(req_write_o)));

   // R8: hard reset withdraws a pending request
   a_r8_abandon_drop: assert property (@(posedge clk) disable iff (!rst_n)
      abandon_i |=> !req_valid_o && !outstanding_o);
endmodule

// File: rtl/dmiac_sticky.sv
module dmiac_sticky
   import dmiac_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set_busy_i,
   input  logic set_err_i,
   input  logic clear_i,
   output dst_e status_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 status_o <= DST_OK;
      else if (clear_i)           status_o <= DST_OK;
      else if (status_o == DST_OK) begin
         if (set_busy_i)          status_o <= DST_BUSY;
         else if (set_err_i)      status_o <= DST_FAIL;
      end
   end

   // R4: busy stays until explicitly cleared
   a_r4_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == DST_BUSY && !clear_i) |=> status_o == DST_BUSY);

   // R5: an error code is also sticky
   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == DST_FAIL && !clear_i) |=> status_o == DST_FAIL);

   // R7: clear returns to success
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> status_o == DST_OK);
endmodule

// File: rtl/dmi_access_ctrl.sv
module dmi_access_ctrl
   import dmiac_pkg::*;
#(
   parameter int ABITS     = 7,
   parameter int DATA_W    = 32,
   parameter int IDLE_HINT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_sel_i,
   input  logic              capture_i,
   input  logic              shift_i,
   input  logic              update_i,
   input  logic              tdi_i,
   output logic              tdo_o,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic              req_write_o,
   output logic [ABITS-1:0]  req_addr_o,
   output logic [DATA_W-1:0] req_wdata_o,
   input  logic              rsp_valid_i,
   input  logic [DATA_W-1:0] rsp_rdata_i,
   input  logic              rsp_err_i
);
   localparam int OP_W    = 2;
   localparam int DATA_LO = OP_W;
   localparam int ADDR_LO = DATA_LO + DATA_W;
   localparam int ACC_W   = ADDR_LO + ABITS;

   if (DATA_W != 32) begin : g_bad_data
      $error("dmi_access_ctrl: version 1 fixes the data field at 32 bits");
   end
   if (ABITS < 1 || ABITS > 63) begin : g_bad_abits
      $error("dmi_access_ctrl: ABITS must fit the 6-bit width field");
   end
   if (IDLE_HINT < 0 || IDLE_HINT > 7) begin : g_bad_idle
      $error("dmi_access_ctrl: IDLE_HINT must fit 3 bits");
   end

   logic acc_cap, acc_sft, acc_upd, csr_cap, csr_sft, csr_upd;
   assign acc_cap = capture_i &&  acc_sel_i;
   assign acc_sft = shift_i   &&  acc_sel_i;
   assign acc_upd = update_i  &&  acc_sel_i;
   assign csr_cap = capture_i && !acc_sel_i;
   assign csr_sft = shift_i   && !acc_sel_i;
   assign csr_upd = update_i  && !acc_sel_i;

   logic [ACC_W-1:0]  acc_q, acc_cap_val;
   logic [CSR_W-1:0]  csr_cap_val;
   logic [1:0]        csr_ctl;
   logic              acc_tdo, csr_tdo;
   dst_e              status;
   logic              outstanding, rsp_err;
   logic [DATA_W-1:0] last_data;

   dop_e acc_op;
   logic is_xfer, issue, set_busy, clear, abandon;

   assign acc_op   = dop_e'(acc_q[OP_W-1:0]);
   assign is_xfer  = (acc_op == DOP_READ) || (acc_op == DOP_WRITE);
   assign issue    = acc_upd && is_xfer && status == DST_OK && !outstanding;
   assign set_busy = acc_upd && is_xfer && status == DST_OK &&  outstanding;
   assign clear    = csr_upd && (|csr_ctl);
   assign abandon  = csr_upd && csr_ctl[1];

   assign acc_cap_val = {req_addr_o, last_data, status};

   always_comb begin
      csr_cap_val         = '0;
      csr_cap_val[3:0]    = 4'(CSR_VERSION);
      csr_cap_val[9:4]    = 6'(ABITS);
      csr_cap_val[11:10]  = status;
      csr_cap_val[14:12]  = 3'(IDLE_HINT);
   end

   dmiac_scanreg #(.W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .load_i(acc_cap), .load_val_i(acc_cap_val),
      .shift_i(acc_sft), .tdi_i(tdi_i), .q_o(acc_q), .tdo_o(acc_tdo)
   );

   dmiac_scanreg #(.W(CSR_W), .TAP_LO(CSR_CLR_BIT), .TAP_HI(CSR_HARD_BIT)) u_csr (
      .clk(clk), .rst_n(rst_n), .load_i(csr_cap), .load_val_i(csr_cap_val),
      .shift_i(csr_sft), .tdi_i(tdi_i), .q_o(csr_ctl), .tdo_o(csr_tdo)
   );

   dmiac_link #(.ABITS(ABITS), .DATA_W(DATA_W)) u_link (
      .clk(clk), .rst_n(rst_n),
      .issue_i(issue), .issue_write_i(acc_op == DOP_WRITE),
      .issue_addr_i(acc_q[ACC_W-1:ADDR_LO]), .issue_data_i(acc_q[ADDR_LO-1:DATA_LO]),
      .abandon_i(abandon),
      .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_write_o(req_write_o),
      .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
      .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i), .rsp_err_i(rsp_err_i),
      .outstanding_o(outstanding), .rsp_err_o(rsp_err), .last_data_o(last_data)
   );

   dmiac_sticky u_sticky (
      .clk(clk), .rst_n(rst_n), .set_busy_i(set_busy), .set_err_i(rsp_err),
      .clear_i(clear), .status_o(status)
   );

   assign tdo_o = acc_sel_i ? acc_tdo : csr_tdo;

   // R3: nop and reserved ops never start a request
   a_r3_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_upd && !is_xfer && !req_valid_o) |=> !req_valid_o);

   // R6: a nonzero status blocks new requests
   a_r6_sticky_block: assert property (@(posedge clk) disable iff (!rst_n)
      (status != DST_OK && !req_valid_o) |=> !req_valid_o);

   // R4: transfer scanned while a request is pending raises busy
   a_r4_busy_on_collide: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_upd && is_xfer && req_valid_o && status == DST_OK) |=> status == DST_BUSY);
endmodule

// File: tb/dmi_access_ctrl_bench.sv
module dmi_access_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ABITS = 7;
   localparam int DW    = 32;
   localparam int ACC_W = ABITS + DW + 2;

   logic clk = 0, rst_n = 0;
   logic acc_sel = 1, capture = 0, shift = 0, update = 0, tdi = 0;
   logic tdo;
   logic req_valid, req_ready = 1, req_write;
   logic [ABITS-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic rsp_valid = 0, rsp_err = 0;
   logic [DW-1:0] rsp_rdata = '0;

   int n_cmp = 0, n_bad = 0;
   int rsp_delay = 3;
   bit err_flag = 0;
   logic [ABITS+DW:0] exp_q[$];   // {write, addr, wdata}

   always #(CLK_PERIOD/2) clk = ~clk;

   dmi_access_ctrl #(.ABITS(ABITS), .DATA_W(DW), .IDLE_HINT(1)) u_dmi_access_ctrl (
      .clk(clk), .rst_n(rst_n), .acc_sel_i(acc_sel), .capture_i(capture),
      .shift_i(shift), .update_i(update), .tdi_i(tdi), .tdo_o(tdo),
      .req_valid_o(req_valid), .req_ready_i(req_ready), .req_write_o(req_write),
      .req_addr_o(req_addr), .req_wdata_o(req_wdata),
      .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata), .rsp_err_i(rsp_err)
   );

   function automatic logic [DW-1:0] rsp_of(logic [ABITS-1:0] a);
      return 32'hC0DE_0000 | {{(DW-ABITS){1'b0}}, a};
   endfunction

   function automatic logic [ACC_W-1:0] accw(logic [ABITS-1:0] a, logic [DW-1:0] d, logic [1:0] op);
      return {a, d, op};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver side of the scoreboard
   task automatic expect_req(bit wr, logic [ABITS-1:0] a, logic [DW-1:0] d);
      exp_q.push_back({wr, a, d});
   endtask

   task automatic scan(input bit sel, input logic [ACC_W-1:0] din, input int w,
                       output logic [ACC_W-1:0] dout);
      dout = '0;
      @(negedge clk); acc_sel = sel; capture = 1;
      @(negedge clk); capture = 0;
      for (int i = 0; i < w; i++) begin
         dout[i] = tdo; tdi = din[i]; shift = 1;
         @(negedge clk);
      end
      shift = 0; update = 1;
      @(negedge clk); update = 0;
   endtask

   // monitor and responder: compares accepted requests with the queue
   initial begin
      bit pend = 0;
      int cnt = 0;
      logic [ABITS-1:0] pa = '0;
      forever begin
         @(negedge clk); #1;
         rsp_valid = 0; rsp_err = 0;
         if (pend) begin
            if (cnt == 0) begin
               rsp_valid = 1; rsp_rdata = rsp_of(pa); rsp_err = err_flag; pend = 0;
            end else cnt--;
         end
         if (rst_n && req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R6: unexpected request actual addr %h expected none", req_addr);
            end else begin
               chk("R2 request", {31'b0, req_write, req_addr, req_wdata}, {31'b0, exp_q.pop_front()});
            end
            pend = 1; cnt = rsp_delay; pa = req_addr;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   localparam logic [ACC_W-1:0] CLR  = ACC_W'(1) << 16;
   localparam logic [ACC_W-1:0] HARD = ACC_W'(1) << 17;
   localparam logic [31:0] CSR_BASE = 32'h0000_1071;

   initial begin
      logic [ACC_W-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk("R1 reset req_valid", {63'b0, req_valid}, 64'd0);
      scan(1, '0, ACC_W, d);
      chk("R1 reset capture", 64'(d), 64'd0);
      scan(0, '0, 32, d);
      chk("R9 csr fields", 64'(d[31:0]), 64'(CSR_BASE));

      // plain read
      expect_req(0, 7'h11, 32'h0);
      scan(1, accw(7'h11, 32'h0, 2'd1), ACC_W, d);
      repeat (10) @(negedge clk);
      scan(1, '0, ACC_W, d);
      chk("R1 read capture", 64'(d), 64'(accw(7'h11, rsp_of(7'h11), 2'd0)));

      // write held off by ready
      req_ready = 0;
      scan(1, accw(7'h22, 32'hDEAD_BEEF, 2'd2), ACC_W, d);
      for (int k = 0; k < 5; k++) begin
         chk("R2 hold", {31'b0, req_valid, req_write, req_addr, req_wdata},
             {31'b0, 1'b1, 1'b1, 7'h22, 32'hDEAD_BEEF});
         @(negedge clk);
      end
      expect_req(1, 7'h22, 32'hDEAD_BEEF);
      req_ready = 1;
      repeat (10) @(negedge clk);
      scan(1, '0, ACC_W, d);
      chk("R1 write capture", 64'(d), 64'(accw(7'h22, rsp_of(7'h22), 2'd0)));

      // busy collision
      rsp_delay = 300;
      expect_req(0, 7'h05, 32'h0);
      scan(1, accw(7'h05, 32'h0, 2'd1), ACC_W, d);
      scan(1, accw(7'h06, 32'h1111_2222, 2'd2), ACC_W, d);
      chk("R1 capture while pending", 64'(d), 64'(accw(7'h05, rsp_of(7'h22), 2'd0)));
      repeat (320) @(negedge clk);
      scan(1, accw(7'h07, 32'h3, 2'd2), ACC_W, d);
      chk("R4 busy status", 64'(d), 64'(accw(7'h05, rsp_of(7'h05), 2'd3)));
      scan(1, '0, ACC_W, d);
      chk("R6 ignored while busy", 64'(d), 64'(accw(7'h05, rsp_of(7'h05), 2'd3)));
      rsp_delay = 3;
      scan(0, CLR, 32, d);
      chk("R9 csr status busy", 64'(d[31:0]), 64'(CSR_BASE | (32'd3 << 10)));
      expect_req(1, 7'h07, 32'h1234_5678);
      scan(1, accw(7'h07, 32'h1234_5678, 2'd2), ACC_W, d);
      repeat (10) @(negedge clk);
      scan(1, '0, ACC_W, d);
      chk("R7 accepted after clear", 64'(d), 64'(accw(7'h07, rsp_of(7'h07), 2'd0)));

      // error response
      err_flag = 1;
      expect_req(0, 7'h09, 32'h0);
      scan(1, accw(7'h09, 32'h0, 2'd1), ACC_W, d);
      repeat (10) @(negedge clk);
      err_flag = 0;
      scan(1, accw(7'h0D, 32'h5, 2'd2), ACC_W, d);
      chk("R5 error status", 64'(d), 64'(accw(7'h09, rsp_of(7'h09), 2'd2)));
      repeat (10) @(negedge clk);
      scan(0, CLR, 32, d);
      chk("R6 still error after dropped write", 64'(d[31:0]), 64'(CSR_BASE | (32'd2 << 10)));

      // reserved op and nop
      scan(1, accw(7'h33, 32'h77, 2'd3), ACC_W, d);
      repeat (10) @(negedge clk);
      scan(1, accw(7'h34, 32'h0, 2'd0), ACC_W, d);
      chk("R3 reserved op no effect", 64'(d), 64'(accw(7'h09, rsp_of(7'h09), 2'd0)));

      // hard reset before acceptance
      req_ready = 0;
      scan(1, accw(7'h0A, 32'h0, 2'd1), ACC_W, d);
      repeat (3) @(negedge clk);
      chk("R8 pending before hard reset", {63'b0, req_valid}, 64'd1);
      scan(0, HARD, 32, d);
      chk("R8 request dropped", {63'b0, req_valid}, 64'd0);
      req_ready = 1;

      // hard reset after acceptance; nop during outstanding
      rsp_delay = 200;
      expect_req(0, 7'h0B, 32'h0);
      scan(1, accw(7'h0B, 32'h0, 2'd1), ACC_W, d);
      repeat (5) @(negedge clk);
      scan(1, '0, ACC_W, d);
      scan(0, HARD, 32, d);
      chk("R3 nop while pending no busy", 64'(d[31:0]), 64'(CSR_BASE));
      repeat (230) @(negedge clk);
      scan(1, '0, ACC_W, d);
      chk("R8 stale response ignored", 64'(d), 64'(accw(7'h0B, rsp_of(7'h09), 2'd0)));
      rsp_delay = 3;
      expect_req(0, 7'h0C, 32'h0);
      scan(1, accw(7'h0C, 32'h0, 2'd1), ACC_W, d);
      repeat (10) @(negedge clk);
      scan(1, '0, ACC_W, d);
      chk("R8 accepted after hard reset", 64'(d), 64'(accw(7'h0C, rsp_of(7'h0C), 2'd0)));

      chk("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule